// File: doc/BRIEF.md
# Control-Endpoint Feature Request Handler

This block sits behind a USB device's control endpoint and decides the outcome of the SET_FEATURE and CLEAR_FEATURE standard requests. When the receiving logic has a complete 8-byte SETUP packet, it raises a one-cycle strobe with the packet bytes and the current device state. One clock later the block answers with a single-cycle pulse on either the accept line or the stall line. The status-stage logic uses that pulse to send a zero-length handshake or a STALL.

The block holds three flags. The first is the halt flag of the single data endpoint (address 0x81). The second is the device remote-wakeup enable. The third is a short-lived control-endpoint stall flag, which goes up with every stalled request and is dropped by the next SETUP. A halt on the control endpoint is never latched. Any request the block does not recognise gets a stall and changes nothing.

The packet is presented little-endian on the wire. Byte i sits at `setup_bytes[8*i+7:8*i]`. Byte 0 is the request type, byte 1 the request code, bytes 2..3 the feature selector, bytes 4..5 the index and bytes 6..7 the length.

Top module: `usb_feature_ctl`

## Requirements
- R1: After reset, hs_ack, hs_stall, ep1_halt, rwake_en and ep0_stall are all 0.
- R2: Every cycle with setup_vld high is followed, exactly one cycle later, by a one-cycle pulse on exactly one of hs_ack or hs_stall. Neither line is high at any other time.
- R3: Setting the halt feature on the control endpoint stalls in every device state. The bytes are 02 03 00 00 xx 00 00 00, where xx = 00 is the OUT direction and xx = 80 is the IN direction. No halt flag changes.
- R4: Setting the halt feature on endpoint 0x81 (02 03 00 00 81 00 00 00) is handled by device state. In Configured (dev_state = 10) it is accepted and sets ep1_halt. In Default (00) and Addressed (01) it stalls and ep1_halt is unchanged.
- R5: Clearing the device remote-wakeup feature (00 01 01 00 00 00 00 00) is accepted in every device state and leaves rwake_en at 0.
- R6: Clearing the halt feature on the control endpoint (02 01 00 00 xx 00 00 00, xx = 00 or 80) is accepted in every device state.
- R7: Clearing the halt feature on endpoint 0x81 (02 01 00 00 81 00 00 00) is handled by device state. In Configured it is accepted and clears ep1_halt. In Default or Addressed it stalls and ep1_halt is unchanged.
- R8: dev_state = 11 gives the same responses and flag changes as Default.
- R9: A packet that matches none of the above stalls and changes no flag. This includes any packet whose length bytes are nonzero.
- R10: ep0_stall rises together with every hs_stall pulse. A new SETUP strobe drops it before the new request is judged, so after each response ep0_stall equals that response's stall outcome.
- R11: ep1_halt, rwake_en and ep0_stall hold their values in every cycle without a SETUP strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| setup_vld | input | 1 | One-cycle strobe: a SETUP packet is present |
| setup_bytes | input | 64 | SETUP packet, byte i at bits 8*i+7:8*i |
| dev_state | input | 2 | 00 Default, 01 Addressed, 10 Configured, 11 as Default |
| hs_ack | output | 1 | One-cycle pulse: accept the status stage |
| hs_stall | output | 1 | One-cycle pulse: stall the status stage |
| ep1_halt | output | 1 | Halt flag of endpoint 0x81 |
| rwake_en | output | 1 | Remote-wakeup enable flag |
| ep0_stall | output | 1 | Control-endpoint stall flag, dropped by the next SETUP |

## Verification
Every result is due at the first clock edge after the strobe edge. That one edge registers both the handshake pulse and the new flag values. The bench drives each strobe on a falling edge and reads all outputs on the following falling edge. One falling edge after that, it confirms that the pulse has ended and that the flags have held. The directed part steps every request form through all four device states. A seeded random part adds corrupted and length-bearing packets and compares each response with a bench model.

// File: rtl/feat_pkg.sv
package feat_pkg;

  typedef enum logic [2:0] {
    REQ_SET_EP0  = 3'd0,
    REQ_SET_EP1  = 3'd1,
    REQ_CLR_DEV  = 3'd2,
    REQ_CLR_EP0  = 3'd3,
    REQ_CLR_EP1  = 3'd4,
    REQ_UNKNOWN  = 3'd5
  } req_kind_e;

  localparam logic [1:0] DST_DEFAULT    = 2'b00;
  localparam logic [1:0] DST_ADDRESSED  = 2'b01;
  localparam logic [1:0] DST_CONFIGURED = 2'b10;

  localparam logic [7:0]  RTYPE_TO_DEVICE = 8'h00;
  localparam logic [7:0]  RTYPE_TO_EP     = 8'h02;
  localparam logic [7:0]  CODE_CLEAR      = 8'h01;
  localparam logic [7:0]  CODE_SET        = 8'h03;
  localparam logic [15:0] SEL_HALT        = 16'h0000;
  localparam logic [15:0] SEL_WAKEUP      = 16'h0001;
  localparam logic [15:0] IDX_CTRL_OUT    = 16'h0000;
  localparam logic [15:0] IDX_CTRL_IN     = 16'h0080;

  typedef struct packed {
    logic accept;
    logic set_halt;
    logic clr_halt;
    logic clr_wake;
  } feat_action_t;

endpackage

// File: rtl/feat_decode.sv
module feat_decode #(
  parameter int         NBYTES   = 8,
  parameter logic [7:0] DATA_EP  = 8'h81,
  localparam int        PKT_W    = NBYTES * 8
) (
  input  logic [PKT_W-1:0]     setup_bytes,
  output feat_pkg::req_kind_e  kind
);
  import feat_pkg::*;

  logic [7:0] byte_q [NBYTES];

  for (genvar i = 0; i < NBYTES; i++) begin : g_unpack
    assign byte_q[i] = setup_bytes[8*i +: 8];
  end

  logic [7:0]  rtype, code;
  logic [15:0] fsel, idx, wlen;
  logic        idx_ctrl, idx_data;

  always_comb begin
    rtype    = byte_q[0];
    code     = byte_q[1];
    fsel     = {byte_q[3], byte_q[2]};
    idx      = {byte_q[5], byte_q[4]};
    wlen     = {byte_q[7], byte_q[6]};
    idx_ctrl = (idx == IDX_CTRL_OUT) || (idx == IDX_CTRL_IN);
    idx_data = (idx == {8'h00, DATA_EP});
  end

  always_comb begin
    kind = REQ_UNKNOWN;
    if (wlen == 16'h0000) begin
      if (rtype == RTYPE_TO_EP && fsel == SEL_HALT) begin
        if (code == CODE_SET) begin
          if (idx_ctrl)      kind = REQ_SET_EP0;
          else if (idx_data) kind = REQ_SET_EP1;
        end else if (code == CODE_CLEAR) begin
          if (idx_ctrl)      kind = REQ_CLR_EP0;
          else if (idx_data) kind = REQ_CLR_EP1;
        end
      end else if (rtype == RTYPE_TO_DEVICE && code == CODE_CLEAR &&
                   fsel == SEL_WAKEUP && idx == 16'h0000) begin
        kind = REQ_CLR_DEV;
      end
    end
  end

endmodule

// File: rtl/feat_policy.sv
module feat_policy (
  input  feat_pkg::req_kind_e    kind,
  input  logic [1:0]             dev_state,
  output feat_pkg::feat_action_t act
);
  import feat_pkg::*;

  logic configured;

  always_comb begin
    configured = (dev_state == DST_CONFIGURED);
    act        = '0;
    unique case (kind)
      REQ_SET_EP0: act.accept = 1'b0;
      REQ_SET_EP1: begin
        act.accept   = configured;
        act.set_halt = configured;
      end
      REQ_CLR_DEV: begin
        act.accept   = 1'b1;
        act.clr_wake = 1'b1;
      end
      REQ_CLR_EP0: act.accept = 1'b1;
      REQ_CLR_EP1: begin
        act.accept   = configured;
        act.clr_halt = configured;
      end
      default:     act.accept = 1'b0;
    endcase
  end

endmodule

// File: rtl/feat_state_regs.sv
module feat_state_regs (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   setup_vld,
  input  feat_pkg::feat_action_t act,
  output logic                   hs_ack,
  output logic                   hs_stall,
  output logic                   ep1_halt,
  output logic                   rwake_en,
  output logic                   ep0_stall
);
  logic ack_d, stall_d, halt_d, wake_d, ep0s_d;
  logic flag_en;

  always_comb begin
    flag_en = setup_vld;
    ack_d   = setup_vld & act.accept;
    stall_d = setup_vld & ~act.accept;
    halt_d  = ep1_halt;
    wake_d  = rwake_en;
    ep0s_d  = ep0_stall;
    if (flag_en) begin
      if (act.set_halt) halt_d = 1'b1;
      if (act.clr_halt) halt_d = 1'b0;
      if (act.clr_wake) wake_d = 1'b0;
      ep0s_d = ~act.accept;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_ack    <= 1'b0;
      hs_stall  <= 1'b0;
      ep1_halt  <= 1'b0;
      rwake_en  <= 1'b0;
      ep0_stall <= 1'b0;
    end else begin
      hs_ack    <= ack_d;
      hs_stall  <= stall_d;
      ep1_halt  <= halt_d;
      rwake_en  <= wake_d;
      ep0_stall <= ep0s_d;
    end
  end

endmodule

// File: rtl/usb_feature_ctl.sv
module usb_feature_ctl #(
  parameter int         NBYTES  = 8,
  parameter logic [7:0] DATA_EP = 8'h81,
  parameter int         SYNC_N  = 2,
  localparam int        PKT_W   = NBYTES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_vld,
  input  logic [PKT_W-1:0] setup_bytes,
  input  logic [1:0]       dev_state,
  output logic             hs_ack,
  output logic             hs_stall,
  output logic             ep1_halt,
  output logic             rwake_en,
  output logic             ep0_stall
);
  import feat_pkg::*;

  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_N-1];

  req_kind_e    kind;
  feat_action_t act;

  feat_decode #(.NBYTES(NBYTES), .DATA_EP(DATA_EP)) u_decode (
    .setup_bytes (setup_bytes),
    .kind        (kind)
  );

  feat_policy u_policy (
    .kind      (kind),
    .dev_state (dev_state),
    .act       (act)
  );

  feat_state_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .setup_vld (setup_vld),
    .act       (act),
    .hs_ack    (hs_ack),
    .hs_stall  (hs_stall),
    .ep1_halt  (ep1_halt),
    .rwake_en  (rwake_en),
    .ep0_stall (ep0_stall)
  );

endmodule

// File: rtl/feat_chk.sv
module feat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       setup_vld,
  input logic [1:0] dev_state,
  input logic       hs_ack,
  input logic       hs_stall,
  input logic       ep1_halt,
  input logic       rwake_en,
  input logic       ep0_stall
);

  // R2
  one_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hs_ack, hs_stall}));

  // R2
  response_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_vld |=> (hs_ack || hs_stall));

  // R2
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_ack || hs_stall) |-> $past(setup_vld));

  // R11
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !setup_vld |=> ($stable(ep1_halt) && $stable(rwake_en) && $stable(ep0_stall)));

  // R4
  halt_set_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ep1_halt) |-> ($past(dev_state) == 2'b10 && hs_ack));

  // R7
  halt_clr_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ep1_halt) |-> ($past(dev_state) == 2'b10 && hs_ack));

  // R10
  ep0_flag_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_stall |-> ep0_stall);

  // R10
  ep0_flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_ack |-> !ep0_stall);

endmodule

bind usb_feature_ctl feat_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .setup_vld (setup_vld),
  .dev_state (dev_state),
  .hs_ack    (hs_ack),
  .hs_stall  (hs_stall),
  .ep1_halt  (ep1_halt),
  .rwake_en  (rwake_en),
  .ep0_stall (ep0_stall)
);

// File: tb/usb_feature_ctl_tb.sv
`timescale 1ns/1ps
module usb_feature_ctl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        setup_vld;
  logic [63:0] setup_bytes;
  logic [1:0]  dev_state;
  logic        hs_ack, hs_stall, ep1_halt, rwake_en, ep0_stall;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic m_halt, m_wake, m_ep0s;

  always #2 clk = ~clk;

  usb_feature_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .setup_vld(setup_vld), .setup_bytes(setup_bytes),
    .dev_state(dev_state), .hs_ack(hs_ack), .hs_stall(hs_stall),
    .ep1_halt(ep1_halt), .rwake_en(rwake_en), .ep0_stall(ep0_stall)
  );

  function automatic logic [63:0] mk(input logic [7:0] rt, input logic [7:0] rq,
                                     input logic [15:0] wv, input logic [15:0] wi,
                                     input logic [15:0] wl);
    return {wl, wi, wv, rq, rt};
  endfunction

  // Model from R3..R9: returns {accept, set_halt, clr_halt}
  function automatic logic [2:0] model(input logic [63:0] p, input logic [1:0] st);
    logic [7:0]  rt, rq;
    logic [15:0] wv, wi, wl;
    logic        cfg, ctl;
    rt = p[7:0]; rq = p[15:8]; wv = p[31:16]; wi = p[47:32]; wl = p[63:48];
    cfg = (st == 2'b10);
    ctl = (wi == 16'h0000) || (wi == 16'h0080);
    if (wl != 16'h0000)                                   return 3'b000;
    if (rt == 8'h02 && wv == 16'h0000 && rq == 8'h03 && ctl) return 3'b000;
    if (rt == 8'h02 && wv == 16'h0000 && rq == 8'h03 && wi == 16'h0081)
      return {cfg, cfg, 1'b0};
    if (rt == 8'h02 && wv == 16'h0000 && rq == 8'h01 && ctl) return 3'b100;
    if (rt == 8'h02 && wv == 16'h0000 && rq == 8'h01 && wi == 16'h0081)
      return {cfg, 1'b0, cfg};
    if (rt == 8'h00 && rq == 8'h01 && wv == 16'h0001 && wi == 16'h0000) return 3'b100;
    return 3'b000;
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic do_req(input logic [63:0] p, input logic [1:0] st, input string req);
    logic [2:0] r;
    r = model(p, st);
    @(negedge clk);
    setup_bytes = p; dev_state = st; setup_vld = 1'b1;
    @(negedge clk);
    setup_vld = 1'b0;
    if (r[1]) m_halt = 1'b1;
    if (r[0]) m_halt = 1'b0;
    m_ep0s = ~r[2];
    chk(req, "hs_ack",    hs_ack,    r[2]);
    chk(req, "hs_stall",  hs_stall,  ~r[2]);
    chk(req, "ep1_halt",  ep1_halt,  m_halt);
    chk(req, "rwake_en",  rwake_en,  m_wake);
    chk("R10", "ep0_stall", ep0_stall, m_ep0s);
    @(negedge clk);
    chk("R2",  "ack end",   hs_ack,    1'b0);
    chk("R2",  "stall end", hs_stall,  1'b0);
    chk("R11", "halt hold", ep1_halt,  m_halt);
    chk("R11", "ep0 hold",  ep0_stall, m_ep0s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] sf0o, sf0i, sf1, cfd, cf0o, cf0i, cf1;
    void'($urandom(32'd5711));
    sf0o = mk(8'h02, 8'h03, 16'h0000, 16'h0000, 16'h0000);
    sf0i = mk(8'h02, 8'h03, 16'h0000, 16'h0080, 16'h0000);
    sf1  = mk(8'h02, 8'h03, 16'h0000, 16'h0081, 16'h0000);
    cfd  = mk(8'h00, 8'h01, 16'h0001, 16'h0000, 16'h0000);
    cf0o = mk(8'h02, 8'h01, 16'h0000, 16'h0000, 16'h0000);
    cf0i = mk(8'h02, 8'h01, 16'h0000, 16'h0080, 16'h0000);
    cf1  = mk(8'h02, 8'h01, 16'h0000, 16'h0081, 16'h0000);
    m_halt = 1'b0; m_wake = 1'b0; m_ep0s = 1'b0;
    rst_n = 1'b0; setup_vld = 1'b0; setup_bytes = '0; dev_state = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "hs_ack",    hs_ack,    1'b0);
    chk("R1", "hs_stall",  hs_stall,  1'b0);
    chk("R1", "ep1_halt",  ep1_halt,  1'b0);
    chk("R1", "rwake_en",  rwake_en,  1'b0);
    chk("R1", "ep0_stall", ep0_stall, 1'b0);

    for (int s = 0; s < 4; s++) begin
      do_req(sf0o, 2'(s), "R3");
      do_req(sf0i, 2'(s), "R3");
      do_req(sf1,  2'(s), (s == 3) ? "R8" : "R4");
      do_req(cf0o, 2'(s), "R6");
      do_req(cf0i, 2'(s), "R6");
      do_req(cfd,  2'(s), "R5");
      do_req(cf1,  2'(s), (s == 3) ? "R8" : "R7");
    end
    // halt set in Configured, then attempted clears outside it
    do_req(sf1, 2'b10, "R4");
    do_req(cf1, 2'b01, "R7");
    do_req(cf1, 2'b11, "R8");
    do_req(cf1, 2'b00, "R7");
    do_req({16'h0002, sf1[47:0]}, 2'b10, "R9");
    do_req({16'h0100, cf1[47:0]}, 2'b10, "R9");
    do_req(mk(8'h02, 8'h03, 16'h0000, 16'h0082, 16'h0000), 2'b10, "R9");
    do_req(mk(8'h00, 8'h03, 16'h0001, 16'h0000, 16'h0000), 2'b10, "R9");
    do_req(cf1, 2'b10, "R7");
    // idle hold
    repeat (5) @(negedge clk);
    chk("R11", "idle halt", ep1_halt,  m_halt);
    chk("R11", "idle ep0",  ep0_stall, m_ep0s);

    for (int k = 0; k < 400; k++) begin
      logic [63:0] p;
      case ($urandom_range(7))
        0: p = sf0o; 1: p = sf0i; 2: p = sf1; 3: p = cfd;
        4: p = cf0o; 5: p = cf0i; 6: p = cf1;
        default: p = {$urandom, $urandom};
      endcase
      if ($urandom_range(3) == 0) begin
        int b;
        b = int'($urandom_range(7));
        p[8*b +: 8] = 8'($urandom);
      end
      do_req(p, 2'($urandom_range(3)), "R9");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule